// File: doc/BRIEF.md
# Oversampling Serial Receive Recovery

This block turns one asynchronous serial receive line into bytes. An external rate generator supplies a single-cycle sample enable at either 16 or 8 times the bit rate. A mode input tells the receiver which of the two rates is in use. The line is brought into the clock domain through a flop synchroniser and examined only on sample enables. Each frame carries one start bit, eight data bits sent least significant bit first, an optional even parity bit and one stop bit.

A falling edge seen at a sample enable while the receiver is idle begins a frame, and the bit timing is re-anchored at that edge for every frame. The start bit is confirmed by a vote of three samples around its centre, so a short low glitch is discarded and the receiver goes back to hunting for an edge. Every later bit is decided by a vote of the three centre samples of that bit. At the centre of the stop bit the block presents the byte with a one-cycle strobe, plus flags for a low stop bit and for a parity mismatch.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, `rx_valid_o`, `frame_err_o` and `parity_err_o` are 0 and `rx_data_o` is all zeros.
- R2: With `fast_mode_i` = 0 each bit spans 16 sample enables, and with `fast_mode_i` = 1 it spans 8. The mode and `parity_en_i` are captured only while the receiver is idle, so changing them during a frame has no effect on that frame.
- R3: A frame begins at a sample enable at which the synchronised line is 0 and was 1 at the previous sample enable. That sample is sample 1 of the start bit. Idle samples before it do not advance the bit timing.
- R4: The start bit is judged by samples 8, 9 and 10 at 16x, or samples 4, 5 and 6 at 8x. If two or more of them are 1, the start is dropped, no byte is produced, and the receiver waits for the next falling edge. A single high sample among the three does not drop the start.
- R5: Each data bit takes the majority value of its three centre samples: samples 8 to 10 at 16x, 4 to 6 at 8x. Samples outside those three have no effect. Bits arrive least significant bit first, so the first data bit lands in `rx_data_o[0]`.
- R6: `rx_valid_o` is high for exactly one clock cycle, in the cycle after the sample enable that takes the last centre sample (sample 10 at 16x, 6 at 8x) of the stop bit. `rx_data_o` then holds the byte.
- R7: `frame_err_o` is 1 together with the strobe when the voted stop bit is 0, and is 0 otherwise.
- R8: When parity is enabled, one parity bit follows the data bits and is voted like a data bit. `parity_err_o` is 1 with the strobe when the voted parity bit differs from the XOR of the eight data bits. When parity is disabled the stop bit follows the data directly and `parity_err_o` stays 0.
- R9: After the stop bit's last centre sample the receiver is idle. A falling edge at the very next sample enable starts a new frame whose timing depends only on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en_i | input | 1 | One-cycle sample enable from the rate generator |
| rx_i | input | 1 | Asynchronous receive line, idle high |
| fast_mode_i | input | 1 | 0 selects 16 samples per bit, 1 selects 8 |
| parity_en_i | input | 1 | 1 adds an even parity bit after the data |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | One-cycle strobe when a byte is presented |
| frame_err_o | output | 1 | Stop bit voted low, valid with the strobe |
| parity_err_o | output | 1 | Parity bit mismatched, valid with the strobe |

## Verification
The bench builds the block with its default parameters: eight data bits, rates of 16 and 8 samples per bit, and a two-flop synchroniser. The rate is chosen at a port, so one build covers both vote windows: the 8/9/10 centre at 16x and the 4/5/6 centre at 8x. Sample enables come every five clocks, so the synchroniser always settles between samples and each sample the bench drives maps to one known sample number. That lets the strobe's sample index be checked exactly, with single samples flipped in and out of the vote windows.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);

  logic [STAGES-1:0] pipe_q;

  // line idles high, so the pipe resets to ones
  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '1;
    else     pipe_q <= {pipe_q[STAGES-2:0], line_i};
  end

  assign line_o = pipe_q[STAGES-1];

endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote (
  input  logic clk,
  input  logic rst,
  input  logic sample_en_i,
  input  logic clear_i,
  input  logic in_win_i,
  input  logic bit_i,
  output logic maj_o
);

  logic [1:0] ones_q;
  logic [2:0] total;

  // count includes the sample being taken this tick
  always_comb begin
    total = {1'b0, ones_q} + {2'b00, in_win_i & bit_i};
    maj_o = (total >= 3'd2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ones_q <= '0;
    end else if (sample_en_i) begin
      if (clear_i)                ones_q <= '0;
      else if (in_win_i && bit_i) ones_q <= ones_q + 2'd1;
    end
  end

endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OSR_NORMAL = 16,
  parameter int OSR_FAST   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_en_i,
  input  logic                 line_i,
  input  logic                 fast_mode_i,
  input  logic                 parity_en_i,
  input  logic                 maj_i,
  output logic                 vote_clear_o,
  output logic                 vote_win_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 frame_err_o,
  output logic                 parity_err_o
);

  localparam int CNT_W = $clog2(OSR_NORMAL + 1);
  localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  rx_state_e            state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [IDX_W-1:0]     idx_q;
  logic [DATA_BITS-1:0] shreg_q;
  logic                 prev_q;
  logic                 fast_q;
  logic                 par_q;
  logic                 par_bit_q;

  logic [CNT_W-1:0] osr, win_lo, win_hi, s_num;
  logic             in_win, last_c, end_bit, fall;

  always_comb begin
    osr    = fast_q ? CNT_W'(OSR_FAST) : CNT_W'(OSR_NORMAL);
    win_lo = osr >> 1;
    win_hi = win_lo + CNT_W'(2);
    // number of the sample taken at this tick
    if (state_q == RX_IDLE || cnt_q == osr) s_num = CNT_W'(1);
    else                                    s_num = cnt_q + CNT_W'(1);
    in_win  = (state_q != RX_IDLE) && (s_num >= win_lo) && (s_num <= win_hi);
    last_c  = (state_q != RX_IDLE) && (s_num == win_hi);
    end_bit = (s_num == osr);
    fall    = (state_q == RX_IDLE) && prev_q && !line_i;
  end

  assign vote_clear_o = (s_num == CNT_W'(1));
  assign vote_win_o   = in_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= RX_IDLE;
      cnt_q        <= '0;
      idx_q        <= '0;
      shreg_q      <= '0;
      prev_q       <= 1'b1;
      fast_q       <= 1'b0;
      par_q        <= 1'b0;
      par_bit_q    <= 1'b0;
      data_o       <= '0;
      valid_o      <= 1'b0;
      frame_err_o  <= 1'b0;
      parity_err_o <= 1'b0;
    end else begin
      valid_o      <= 1'b0;
      frame_err_o  <= 1'b0;
      parity_err_o <= 1'b0;
      if (state_q == RX_IDLE) begin
        fast_q <= fast_mode_i;
        par_q  <= parity_en_i;
      end
      if (sample_en_i) begin
        prev_q <= line_i;
        unique case (state_q)
          RX_IDLE: begin
            if (fall) begin
              state_q <= RX_START;
              cnt_q   <= CNT_W'(1);
            end
          end
          RX_START: begin
            cnt_q <= s_num;
            if (last_c && maj_i) begin
              state_q <= RX_IDLE;
            end else if (end_bit) begin
              state_q <= RX_DATA;
              idx_q   <= '0;
            end
          end
          RX_DATA: begin
            cnt_q <= s_num;
            if (last_c) shreg_q <= {maj_i, shreg_q[DATA_BITS-1:1]};
            if (end_bit) begin
              if (idx_q == IDX_W'(DATA_BITS - 1)) state_q <= par_q ? RX_PAR : RX_STOP;
              else                                idx_q   <= idx_q + IDX_W'(1);
            end
          end
          RX_PAR: begin
            cnt_q <= s_num;
            if (last_c)  par_bit_q <= maj_i;
            if (end_bit) state_q   <= RX_STOP;
          end
          RX_STOP: begin
            cnt_q <= s_num;
            if (last_c) begin
              valid_o      <= 1'b1;
              data_o       <= shreg_q;
              frame_err_o  <= !maj_i;
              parity_err_o <= par_q && (par_bit_q != (^shreg_q));
              state_q      <= RX_IDLE;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R6
  AST_FERR_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |-> valid_o); // R7
  AST_PERR_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    parity_err_o |-> (valid_o && par_q)); // R8
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (state_q != RX_IDLE) |-> (cnt_q >= CNT_W'(1) && cnt_q <= osr)); // R2
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (state_q != RX_IDLE && $past(state_q) != RX_IDLE) |-> ($stable(fast_q) && $stable(par_q))); // R2
  AST_START_AT_ONE: assert property (@(posedge clk) disable iff (rst)
    (state_q == RX_START && $past(state_q) == RX_IDLE) |-> (cnt_q == CNT_W'(1))); // R3

endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int DATA_BITS   = 8,
  parameter int OSR_NORMAL  = 16,
  parameter int OSR_FAST    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_en_i,
  input  logic                 rx_i,
  input  logic                 fast_mode_i,
  input  logic                 parity_en_i,
  output logic [DATA_BITS-1:0] rx_data_o,
  output logic                 rx_valid_o,
  output logic                 frame_err_o,
  output logic                 parity_err_o
);

  logic line_s, maj, vote_clear, vote_win;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst    (rst),
    .line_i (rx_i),
    .line_o (line_s)
  );

  uart_rx_vote vote_i (
    .clk         (clk),
    .rst         (rst),
    .sample_en_i (sample_en_i),
    .clear_i     (vote_clear),
    .in_win_i    (vote_win),
    .bit_i       (line_s),
    .maj_o       (maj)
  );

  uart_rx_ctrl #(
    .DATA_BITS  (DATA_BITS),
    .OSR_NORMAL (OSR_NORMAL),
    .OSR_FAST   (OSR_FAST)
  ) ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .sample_en_i  (sample_en_i),
    .line_i       (line_s),
    .fast_mode_i  (fast_mode_i),
    .parity_en_i  (parity_en_i),
    .maj_i        (maj),
    .vote_clear_o (vote_clear),
    .vote_win_o   (vote_win),
    .data_o       (rx_data_o),
    .valid_o      (rx_valid_o),
    .frame_err_o  (frame_err_o),
    .parity_err_o (parity_err_o)
  );

endmodule

// File: tb/uart_os_rx_tb_top.sv
module uart_os_rx_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sample_en = 1'b0;
  logic       rx = 1'b1;
  logic       fast = 1'b0;
  logic       par_en = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, ferr, perr;

  int checks = 0, fails = 0, tick_num = 0;
  int strobes = 0, valid_tick = -1;
  logic [7:0] cap_data, first_data;
  logic cap_ferr, cap_perr, prev_v = 1'b0;
  bit double_pulse = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_os_rx dut_i (
    .clk (clk), .rst (rst), .sample_en_i (sample_en), .rx_i (rx),
    .fast_mode_i (fast), .parity_en_i (par_en), .rx_data_o (rx_data),
    .rx_valid_o (rx_valid), .frame_err_o (ferr), .parity_err_o (perr)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      if (strobes == 0) first_data = rx_data;
      strobes++;
      valid_tick = tick_num;
      cap_data = rx_data;
      cap_ferr = ferr;
      cap_perr = perr;
      if (prev_v) double_pulse = 1;
    end
    prev_v = rx_valid;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input logic v);
    @(negedge clk) rx = v;
    repeat (3) @(negedge clk);
    sample_en = 1'b1;
    tick_num++;
    @(negedge clk) sample_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b1);
  endtask

  task automatic clear_mon();
    strobes = 0; double_pulse = 0; valid_tick = -1;
  endtask

  // bit index b: 0 start, 1..8 data, then parity, then stop
  task automatic send_frame(input logic [7:0] d, input bit fastm, input bit par_on,
                            input bit par_v, input bit stop_v, input int stop_len,
                            input int gbit, input logic [15:0] gmask, input bit flip_mode,
                            output int first_tick);
    int osr, nb;
    logic v;
    osr = fastm ? 8 : 16;
    fast = fastm;
    par_en = par_on;
    nb = par_on ? 11 : 10;
    first_tick = 0;
    for (int b = 0; b < nb; b++) begin
      if (b == 0)                v = 1'b0;
      else if (b <= 8)           v = d[b-1];
      else if (par_on && b == 9) v = par_v;
      else                       v = stop_v;
      for (int k = 0; k < ((b == nb - 1) ? stop_len : osr); k++) begin
        tick(v ^ ((b == gbit) ? gmask[k] : 1'b0));
        if (b == 0 && k == 0) first_tick = tick_num;
        if (flip_mode && b == 0 && k == 2) begin
          fast = ~fast;
          par_en = ~par_en;
        end
      end
    end
  endtask

  function automatic int exp_tick(input int first, input bit fastm, input bit par_on);
    int osr;
    osr = fastm ? 8 : 16;
    return first + (par_on ? 10 : 9) * osr + osr / 2 + 1;
  endfunction

  task automatic t_reset();
    chk("R1", "valid after reset", rx_valid, 0);
    chk("R1", "data after reset", rx_data, 0);
    chk("R1", "frame_err after reset", ferr, 0);
    chk("R1", "parity_err after reset", perr, 0);
  endtask

  task automatic t_normal();
    int ft;
    clear_mon();
    idle(23);
    send_frame(8'hA5, 0, 0, 0, 1, 16, -1, 16'h0, 0, ft);
    idle(3);
    chk("R5", "normal data", cap_data, 8'hA5);
    chk("R3", "strobe sample index after long idle", valid_tick, exp_tick(ft, 0, 0));
    chk("R6", "single strobe count", strobes, 1);
    chk("R6", "strobe width one", double_pulse, 0);
    chk("R7", "frame_err clear", cap_ferr, 0);
    chk("R8", "parity_err clear when disabled", cap_perr, 0);
  endtask

  task automatic t_fast();
    int ft;
    clear_mon();
    send_frame(8'h3C, 1, 0, 0, 1, 8, -1, 16'h0, 0, ft);
    idle(3);
    chk("R2", "fast data", cap_data, 8'h3C);
    chk("R2", "fast strobe index", valid_tick, exp_tick(ft, 1, 0));
    fast = 0;
  endtask

  task automatic t_noise();
    int ft;
    clear_mon();
    for (int k = 0; k < 8; k++) tick(1'b0);
    idle(30);
    chk("R4", "16x spike no strobe", strobes, 0);
    fast = 1;
    for (int k = 0; k < 4; k++) tick(1'b0);
    idle(20);
    chk("R4", "8x spike no strobe", strobes, 0);
    send_frame(8'h5A, 0, 0, 0, 1, 16, -1, 16'h0, 0, ft);
    idle(3);
    chk("R4", "frame after spike", cap_data, 8'h5A);
    chk("R4", "index after spike", valid_tick, exp_tick(ft, 0, 0));
  endtask

  task automatic t_start_one_high();
    int ft;
    clear_mon();
    send_frame(8'h81, 0, 0, 0, 1, 16, 0, 16'h0100, 0, ft);
    idle(3);
    chk("R4", "start with one high centre sample", cap_data, 8'h81);
    chk("R4", "strobe count", strobes, 1);
  endtask

  task automatic t_glitch();
    int ft;
    clear_mon();
    send_frame(8'h00, 0, 0, 0, 1, 16, 7, 16'hFC7F, 0, ft);
    idle(3);
    chk("R5", "outside samples ignored", cap_data, 8'h00);
    send_frame(8'h00, 0, 0, 0, 1, 16, 4, 16'h0100, 0, ft);
    idle(3);
    chk("R5", "single centre flip outvoted", cap_data, 8'h00);
    send_frame(8'hFF, 0, 0, 0, 1, 16, 3, 16'h0180, 0, ft);
    idle(3);
    chk("R5", "two centre flips win", cap_data, 8'hFB);
    send_frame(8'hFF, 1, 0, 0, 1, 8, 1, 16'h0018, 0, ft);
    idle(3);
    chk("R5", "8x window flips bit 0", cap_data, 8'hFE);
    fast = 0;
  endtask

  task automatic t_frame_err();
    int ft;
    clear_mon();
    send_frame(8'h42, 0, 0, 0, 0, 16, -1, 16'h0, 0, ft);
    idle(20);
    chk("R7", "frame_err set", cap_ferr, 1);
    chk("R7", "data with frame_err", cap_data, 8'h42);
    send_frame(8'h24, 0, 0, 0, 1, 16, -1, 16'h0, 0, ft);
    idle(3);
    chk("R7", "frame_err clear next frame", cap_ferr, 0);
  endtask

  task automatic t_parity();
    int ft;
    clear_mon();
    send_frame(8'h96, 0, 1, 0, 1, 16, -1, 16'h0, 0, ft);
    idle(3);
    chk("R8", "good parity flag", cap_perr, 0);
    chk("R8", "data with parity", cap_data, 8'h96);
    chk("R8", "strobe index with parity", valid_tick, exp_tick(ft, 0, 1));
    send_frame(8'h97, 1, 1, 0, 1, 8, -1, 16'h0, 0, ft);
    idle(3);
    chk("R8", "bad parity flag", cap_perr, 1);
    chk("R7", "stop ok with bad parity", cap_ferr, 0);
    fast = 0; par_en = 0;
  endtask

  task automatic t_mode_hold();
    int ft;
    clear_mon();
    send_frame(8'hC3, 0, 0, 0, 1, 16, -1, 16'h0, 1, ft);
    idle(3);
    chk("R2", "mode change mid frame ignored", cap_data, 8'hC3);
    chk("R2", "timing kept at 16x", valid_tick, exp_tick(ft, 0, 0));
    chk("R8", "parity enable mid frame ignored", cap_perr, 0);
    fast = 0; par_en = 0;
    idle(2);
  endtask

  task automatic t_back_to_back();
    int ft1, ft2;
    clear_mon();
    send_frame(8'h11, 0, 0, 0, 1, 10, -1, 16'h0, 0, ft1);
    send_frame(8'hEE, 0, 0, 0, 1, 16, -1, 16'h0, 0, ft2);
    idle(3);
    chk("R9", "two strobes", strobes, 2);
    chk("R9", "first byte", first_data, 8'h11);
    chk("R9", "second byte", cap_data, 8'hEE);
    chk("R9", "second index", valid_tick, exp_tick(ft2, 0, 0));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_normal();
    t_fast();
    t_noise();
    t_start_one_high();
    t_glitch();
    t_frame_err();
    t_parity();
    t_mode_hold();
    t_back_to_back();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule